// File: doc/BRIEF.md
# Raster dot and line timer

This block paces a video frame. It keeps a horizontal dot counter and a line counter for a raster of 341 dots by 262 lines, and an even/odd frame flag that flips each time the frame wraps. Other logic decodes its outputs into the strobes that drive fetching and pixel output. This block only counts, clears and skips.

The final line of the frame is the pre-render line. On frames whose odd flag is set, and only while the rendering-enable input is high, that line ends one dot early. The block reaches this by feeding a second term into the end-of-line condition: the last-but-one dot of the pre-render line. The next cycle is dot 0 of line 0, so such a frame is one dot shorter than usual. An even frame always runs its full length. An odd frame runs its full length when rendering is off at that dot.

The line position is tracked by a small state machine with three states. PH_ACTIVE covers the visible lines. PH_BLANK covers the blanking lines. PH_PRE is the single pre-render line. There are three transitions. ACTIVE_TO_BLANK fires at the end of the last visible line. BLANK_TO_PRE fires at the end of the line just before the last line. PRE_TO_ACTIVE fires at the end of the pre-render line; this is the frame wrap, and it also flips the odd flag. In every other cycle the state holds.

Top module: `raster_timer`

## Requirements
- R1: A synchronous reset forces dot 0, line 0, odd flag 0 (even frame) and state PH_ACTIVE, in the cycle after the reset is sampled.
- R2: When no line end occurs, the dot counter rises by exactly 1 per clock and never exceeds H_TOTAL-1 (340).
- R3: At dot H_TOTAL-1 (340) the line ends: the next cycle shows dot 0 and the line number plus 1. In cycles with no line end, the line number is unchanged.
- R4: When a line ends on the last line (V_TOTAL-1 = 261), the line counter returns to 0 and the odd flag inverts. At no other time does the odd flag change.
- R5: If the odd flag is 1 and render_en is 1 at dot H_TOTAL-2 (339) of the last line, the line ends there. The next cycle is dot 0, line 0.
- R6: On an even frame the last line runs to dot H_TOTAL-1, whatever the value of render_en.
- R7: On an odd frame with render_en low at dot H_TOTAL-2 of the last line, the last line runs to dot H_TOTAL-1.
- R8: frame_start is 1 exactly in the cycles where dot is 0 and line is 0.
- R9: A full-length frame lasts H_TOTAL×V_TOTAL clocks (89342). A shortened frame lasts one clock fewer (89341). Both are measured between frame_start pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per dot |
| rst | input | 1 | Synchronous reset, active high |
| render_en | input | 1 | Rendering enabled; allows the odd-frame early line end |
| dot | output | $clog2(H_TOTAL) | Current dot within the line |
| line | output | $clog2(V_TOTAL) | Current line within the frame |
| odd_frame | output | 1 | 1 during odd frames |
| frame_start | output | 1 | High in the first dot of line 0 |

## Verification
The bench targets the dot where the skip decision is made. An off-by-one in the skip compare would end the pre-render line at the wrong dot and give a frame one dot too long or too short. Leaving out the odd-flag or render term would shorten even frames, or frames with rendering off. The bench also checks the wrap of the last line and the odd-flag toggle at each wrap. A design that missed the clear would count past the last line. A design that never toggled the flag would shorten every frame or none. The bench toggles render_en mid-frame and asserts reset part way through a frame, so it also catches an enable sampled at the wrong dot and a reset that leaves stale state behind.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Vertical region of the current line
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_BLANK  = 2'd1,
        PH_PRE    = 2'd2
    } phase_t;

endpackage

// File: rtl/raster_dot_ctr.sv
module raster_dot_ctr #(
    parameter int H_TOTAL = 341,
    localparam int DW = $clog2(H_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    output logic [DW-1:0] dot
);

    localparam logic [DW-1:0] DOT_LAST = DW'(H_TOTAL - 1);

    always_ff @(posedge clk) begin
        if (rst)
            dot <= '0;
        else if (line_end)
            dot <= '0;
        else
            dot <= dot + DW'(1);
    end

    // R2: steady step when no line end
    a_r2_dot_step: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> dot == $past(dot) + DW'(1));

    // R2: range
    a_r2_dot_range: assert property (@(posedge clk) disable iff (rst)
        dot <= DOT_LAST);

    // R3: clear after line end
    a_r3_dot_clear: assert property (@(posedge clk) disable iff (rst)
        line_end |=> dot == '0);

endmodule

// File: rtl/raster_line_ctr.sv
module raster_line_ctr #(
    parameter int V_TOTAL = 262,
    localparam int LW = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    input  logic          frame_end,
    output logic [LW-1:0] line
);

    localparam logic [LW-1:0] LINE_LAST = LW'(V_TOTAL - 1);

    always_ff @(posedge clk) begin
        if (rst)
            line <= '0;
        else if (frame_end)
            line <= '0;
        else if (line_end)
            line <= line + LW'(1);
    end

    // R3: step at a line end inside the frame
    a_r3_line_step: assert property (@(posedge clk) disable iff (rst)
        (line_end && !frame_end) |=> line == $past(line) + LW'(1));

    // R3: hold between line ends
    a_r3_line_hold: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(line));

    // R4: wrap to zero
    a_r4_line_wrap: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> line == '0);

    // R4: never beyond the last line
    a_r4_line_range: assert property (@(posedge clk) disable iff (rst)
        line <= LINE_LAST);

endmodule

// File: rtl/raster_phase_fsm.sv
module raster_phase_fsm
    import raster_pkg::*;
#(
    parameter int V_TOTAL  = 262,
    parameter int V_ACTIVE = 240,
    localparam int LW = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    input  logic [LW-1:0] line,
    output phase_t        phase,
    output logic          odd_frame,
    output logic          frame_end
);

    localparam logic [LW-1:0] LINE_VIS_LAST = LW'(V_ACTIVE - 1);
    localparam logic [LW-1:0] LINE_BLK_LAST = LW'(V_TOTAL - 2);
    localparam logic [LW-1:0] LINE_LAST     = LW'(V_TOTAL - 1);

    phase_t phase_nx;
    logic   odd_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_ACTIVE;
            odd_frame <= 1'b0;
        end else begin
            phase     <= phase_nx;
            odd_frame <= odd_nx;
        end
    end

    // next state
    always_comb begin
        phase_nx = phase;
        odd_nx   = odd_frame;
        unique case (phase)
            PH_ACTIVE: if (line_end && line == LINE_VIS_LAST) phase_nx = PH_BLANK;
            PH_BLANK:  if (line_end && line == LINE_BLK_LAST) phase_nx = PH_PRE;
            PH_PRE: if (line_end) begin
                phase_nx = PH_ACTIVE;
                odd_nx   = ~odd_frame;
            end
            default:   phase_nx = PH_ACTIVE;
        endcase
    end

    // outputs
    always_comb begin
        frame_end = line_end && (phase == PH_PRE);
    end

    // R4: flag flips at each wrap
    a_r4_odd_toggle: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> odd_frame != $past(odd_frame));

    // R4: flag steady otherwise
    a_r4_odd_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(odd_frame));

    // R4: pre-render state only on the last line
    a_r4_pre_line: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PRE) |-> line == LINE_LAST);

endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
#(
    parameter int H_TOTAL  = 341,
    parameter int V_TOTAL  = 262,
    parameter int V_ACTIVE = 240,
    localparam int DW = $clog2(H_TOTAL),
    localparam int LW = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          render_en,
    output logic [DW-1:0] dot,
    output logic [LW-1:0] line,
    output logic          odd_frame,
    output logic          frame_start
);

    localparam logic [DW-1:0] DOT_LAST = DW'(H_TOTAL - 1);
    localparam logic [DW-1:0] DOT_SKIP = DW'(H_TOTAL - 2);
    localparam logic [LW-1:0] LINE_LAST = LW'(V_TOTAL - 1);

    phase_t phase;
    logic   line_end;
    logic   early_end;
    logic   frame_end;

    // second input to the end-of-line term: odd frame, rendering on
    always_comb begin
        early_end = (phase == PH_PRE) && odd_frame && render_en && (dot == DOT_SKIP);
        line_end  = (dot == DOT_LAST) || early_end;
        frame_start = (phase == PH_ACTIVE) && (line == '0) && (dot == '0);
    end

    raster_dot_ctr #(.H_TOTAL(H_TOTAL)) u_dot (
        .clk      (clk),
        .rst      (rst),
        .line_end (line_end),
        .dot      (dot)
    );

    raster_line_ctr #(.V_TOTAL(V_TOTAL)) u_line (
        .clk       (clk),
        .rst       (rst),
        .line_end  (line_end),
        .frame_end (frame_end),
        .line      (line)
    );

    raster_phase_fsm #(.V_TOTAL(V_TOTAL), .V_ACTIVE(V_ACTIVE)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .line_end  (line_end),
        .line      (line),
        .phase     (phase),
        .odd_frame (odd_frame),
        .frame_end (frame_end)
    );

    // R1: reset state
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (dot == '0 && line == '0 && !odd_frame));

    // R5: early end on odd frames with rendering
    a_r5_skip: assert property (@(posedge clk) disable iff (rst)
        (odd_frame && render_en && line == LINE_LAST && dot == DOT_SKIP)
        |=> (dot == '0 && line == '0));

    // R6: even frames keep the last dot
    a_r6_even_full: assert property (@(posedge clk) disable iff (rst)
        (!odd_frame && line == LINE_LAST && dot == DOT_SKIP) |=> dot == DOT_LAST);

    // R7: rendering off keeps the last dot
    a_r7_off_full: assert property (@(posedge clk) disable iff (rst)
        (!render_en && line == LINE_LAST && dot == DOT_SKIP) |=> dot == DOT_LAST);

    // R8: pulse at the origin only
    a_r8_start: assert property (@(posedge clk) disable iff (rst)
        frame_start == (dot == '0 && line == '0));

endmodule

// File: tb/raster_timer_tb.sv
module raster_timer_tb;

    localparam int H = 12;
    localparam int V = 6;
    localparam int VA = 4;
    localparam int DW = $clog2(H);
    localparam int LW = $clog2(V);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          render_en = 1'b0;
    logic [DW-1:0] dot;
    logic [LW-1:0] line;
    logic          odd_frame;
    logic          frame_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int e_dot = 0, e_line = 0, e_odd = 0;
    int flen = 0;
    bit seen_start = 1'b0;
    bit e_short = 1'b0;
    bit last_odd = 1'b0;

    always #10 clk = ~clk;

    raster_timer #(.H_TOTAL(H), .V_TOTAL(V), .V_ACTIVE(VA)) u_dut (
        .clk(clk), .rst(rst), .render_en(render_en),
        .dot(dot), .line(line), .odd_frame(odd_frame), .frame_start(frame_start)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // advance one dot; the model follows the requirements
    task automatic step();
        bit skip;
        bit lend;
        string tag;
        skip = (e_odd == 1) && render_en && (e_line == V - 1) && (e_dot == H - 2);
        lend = skip || (e_dot == H - 1);
        tag = skip ? "R5" : (e_line == V - 1 && e_dot == H - 2) ?
              (e_odd == 1 ? "R7" : "R6") : lend ? ((e_line == V - 1) ? "R4" : "R3") : "R2";
        if (skip) e_short = 1'b1;
        if (lend) begin
            e_dot = 0;
            if (e_line == V - 1) begin
                e_line = 0;
                e_odd = 1 - e_odd;
            end else begin
                e_line++;
            end
        end else begin
            e_dot++;
        end
        @(posedge clk);
        @(negedge clk);
        flen++;
        chk({tag, " dot"}, int'(dot), e_dot);
        chk({tag, " line"}, int'(line), e_line);
        chk("R4 odd", int'(odd_frame), e_odd);
        chk("R8 frame_start", int'(frame_start), (e_dot == 0 && e_line == 0) ? 1 : 0);
        if (e_dot == 0 && e_line == 0) begin
            if (seen_start)
                chk(e_short ? "R9 short frame length" : "R9 full frame length",
                    flen, e_short ? H * V - 1 : H * V);
            seen_start = 1'b1;
            flen = 0;
            e_short = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        e_dot = 0; e_line = 0; e_odd = 0;
        chk("R1 dot", int'(dot), 0);
        chk("R1 line", int'(line), 0);
        chk("R1 odd", int'(odd_frame), 0);
        chk("R8 frame_start at reset", int'(frame_start), 1);
        rst = 1'b0;
        seen_start = 1'b1;
        flen = 0;
        e_short = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // rendering on: alternating full and short frames (R5, R6)
        render_en = 1'b1;
        for (int i = 0; i < 4 * H * V; i++) step();
        // rendering off: every frame full (R7)
        render_en = 1'b0;
        for (int i = 0; i < 4 * H * V; i++) step();
        // enable toggled mid-frame; only its value at the skip dot counts
        for (int i = 0; i < 4 * H * V; i++) begin
            render_en = ((i / 7) % 2) == 1;
            step();
        end
        // enable raised only across the skip dot of an odd frame
        render_en = 1'b0;
        for (int i = 0; i < 3 * H * V; i++) begin
            render_en = (e_line == V - 1 && e_dot == H - 2);
            step();
        end
        render_en = 1'b1;
        // reset part way through a frame (R1)
        for (int i = 0; i < 5 * H + 3; i++) step();
        do_reset();
        for (int i = 0; i < 2 * H * V; i++) step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule